// File: doc/BRIEF.md
# Row and Column Bypassing Array Multiplier

An unsigned WIDTH×WIDTH array multiplier (WIDTH = 12 by default). It is built from a grid of carry-save adder cells. Row 0 is formed directly from the partial products a·b[0]. Each later row j adds the partial products a·b[j] to the shifted sums and carries of the row above. A ripple adder then resolves the last row into the upper half of the product.

Every adder cell decides locally whether it has work to do. If its partial-product bit a[i]·b[j] is 0 and its incoming carry is 0, the cell is bypassed. It then forwards the sum bit from the row above unchanged and drives a 0 carry, and its adder does not switch. A zero multiplier bit therefore idles most of a row, and a zero multiplicand bit idles a column, unless a carry is still moving through.

The combinational product is registered once on the rising clock edge. The per-cell enable pattern is exposed combinationally from the current operands, so the skipping behaviour can be observed and checked.

Top module: `rcb_mult`

## Requirements
- R1: `p_o` equals the unsigned product `a_i × b_i` sampled at the previous rising edge of `clk_i`, for all operand values (latency of one clock).
- R2: While `rst_ni` is low, `p_o` is 0, independent of the clock and of the operands.
- R3: Cell (i, j), for row j in 1..WIDTH-1 and column i in 0..WIDTH-1, reports its adder state on `en_o[(j-1)*WIDTH + i]` in the same cycle as the operands. The bit is 1 whenever `a_i[i] & b_i[j]` is 1.
- R4: With `a_i` = 0, every bit of `en_o` is 0.
- R5: With `b_i` = 0, every bit of `en_o` is 0.
- R6: With exactly one bit of `a_i` set, no carry is ever generated, so the number of set `en_o` bits equals the number of set bits in `b_i[WIDTH-1:1]`.
- R7: With exactly one bit of `b_i` set, the number of set `en_o` bits equals the number of set bits in `a_i` when that bit is above bit 0, and is 0 when it is bit 0.
- R8: A bypassed cell passes its incoming sum unchanged and produces no carry. The product stays exact for zero, all-ones, single-bit and random operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; product register updates on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, clears the product |
| a_i | input | WIDTH | Multiplicand |
| b_i | input | WIDTH | Multiplier |
| p_o | output | 2*WIDTH | Registered product |
| en_o | output | (WIDTH-1)*WIDTH | Adder-active flag per cell, index (row-1)*WIDTH + column |

## Verification
The enable pattern is combinational. The bench checks it one time unit after each operand change, in the same half-cycle as the stimulus. The product is due one rising edge after the operands are applied. The driver pushes each expected product into a queue as it applies the operands. The monitor pops one entry two time units after each rising edge, once the register has settled. This keeps the comparison exactly one edge behind the stimulus. Reset clearing is checked mid-cycle while the clock is still running.

// File: rtl/rcb_mult_pkg.sv
`timescale 1ns/1ps
package rcb_mult_pkg;
  // Flat position of cell (row, col) in the enable vector; row starts at 1
  function automatic int unsigned cell_idx(int unsigned row, int unsigned col,
                                           int unsigned width);
    return (row - 1) * width + col;
  endfunction
endpackage

// File: rtl/rcb_cell.sv
`timescale 1ns/1ps
module rcb_cell (
  input  logic pp_i,
  input  logic sum_i,
  input  logic carry_i,
  output logic sum_o,
  output logic carry_o,
  output logic en_o
);
  logic [1:0] fa_w;

  assign en_o    = pp_i | carry_i;
  assign fa_w    = {1'b0, pp_i} + {1'b0, sum_i} + {1'b0, carry_i};
  // bypassed: pass sum through, kill carry
  assign sum_o   = en_o ? fa_w[0] : sum_i;
  assign carry_o = en_o & fa_w[1];
endmodule

// File: rtl/rcb_array.sv
`timescale 1ns/1ps
module rcb_array
  import rcb_mult_pkg::*;
#(
  parameter int unsigned WIDTH = 12
) (
  input  logic [WIDTH-1:0]             a_i,
  input  logic [WIDTH-1:0]             b_i,
  output logic [WIDTH-1:0]             low_o,
  output logic [WIDTH-2:0]             sum_last_o,
  output logic [WIDTH-1:0]             carry_last_o,
  output logic [(WIDTH-1)*WIDTH-1:0]   en_o
);
  logic [WIDTH-1:0][WIDTH-1:0] s_w;
  logic [WIDTH-1:0][WIDTH-1:0] c_w;

  assign s_w[0] = a_i & {WIDTH{b_i[0]}};
  assign c_w[0] = '0;

  for (genvar j = 1; j < WIDTH; j++) begin : g_row
    for (genvar i = 0; i < WIDTH; i++) begin : g_col
      logic sum_in;
      if (i == WIDTH - 1) begin : g_edge
        assign sum_in = 1'b0;
      end else begin : g_inner
        assign sum_in = s_w[j-1][i+1];
      end
      rcb_cell u_cell (
        .pp_i    (a_i[i] & b_i[j]),
        .sum_i   (sum_in),
        .carry_i (c_w[j-1][i]),
        .sum_o   (s_w[j][i]),
        .carry_o (c_w[j][i]),
        .en_o    (en_o[cell_idx(j, i, WIDTH)])
      );
    end
  end

  for (genvar j = 0; j < WIDTH; j++) begin : g_low
    assign low_o[j] = s_w[j][0];
  end

  assign sum_last_o   = s_w[WIDTH-1][WIDTH-1:1];
  assign carry_last_o = c_w[WIDTH-1];
endmodule

// File: rtl/rcb_ripple.sv
`timescale 1ns/1ps
module rcb_ripple #(
  parameter int unsigned WIDTH = 12
) (
  input  logic [WIDTH-2:0] sum_i,
  input  logic [WIDTH-1:0] carry_i,
  output logic [WIDTH-1:0] hi_o
);
  logic [WIDTH-1:0] x_w;
  logic [WIDTH-1:0] r_w;

  assign x_w    = {1'b0, sum_i};
  assign r_w[0] = 1'b0;

  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    assign hi_o[k] = x_w[k] ^ carry_i[k] ^ r_w[k];
    // top carry-out is always 0 for a 2*WIDTH product
    if (k < WIDTH - 1) begin : g_c
      assign r_w[k+1] = (x_w[k] & carry_i[k]) | (r_w[k] & (x_w[k] ^ carry_i[k]));
    end
  end
endmodule

// File: rtl/rcb_mult.sv
`timescale 1ns/1ps
module rcb_mult #(
  parameter int unsigned WIDTH = 12
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [WIDTH-1:0]               a_i,
  input  logic [WIDTH-1:0]               b_i,
  output logic [2*WIDTH-1:0]             p_o,
  output logic [(WIDTH-1)*WIDTH-1:0]     en_o
);
  logic [WIDTH-1:0] low_w;
  logic [WIDTH-2:0] sum_last_w;
  logic [WIDTH-1:0] carry_last_w;
  logic [WIDTH-1:0] hi_w;

  rcb_array #(.WIDTH(WIDTH)) u_array (
    .a_i          (a_i),
    .b_i          (b_i),
    .low_o        (low_w),
    .sum_last_o   (sum_last_w),
    .carry_last_o (carry_last_w),
    .en_o         (en_o)
  );

  rcb_ripple #(.WIDTH(WIDTH)) u_ripple (
    .sum_i   (sum_last_w),
    .carry_i (carry_last_w),
    .hi_o    (hi_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) p_o <= '0;
    else         p_o <= {hi_w, low_w};
  end
endmodule

// File: rtl/rcb_mult_chk.sv
`timescale 1ns/1ps
module rcb_mult_chk #(
  parameter int unsigned WIDTH = 12
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [WIDTH-1:0]             a_i,
  input logic [WIDTH-1:0]             b_i,
  input logic [2*WIDTH-1:0]           p_o,
  input logic [(WIDTH-1)*WIDTH-1:0]   en_o
);
  logic [2*WIDTH-1:0] ref_w;
  assign ref_w = {{WIDTH{1'b0}}, a_i} * {{WIDTH{1'b0}}, b_i};

  p_product_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> p_o == $past(ref_w));

  p_reset_r2: assert property (@(posedge clk_i)
    !rst_ni |-> p_o == '0);

  for (genvar j = 1; j < WIDTH; j++) begin : g_r3
    p_pp_active_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_o[(j-1)*WIDTH +: WIDTH] & (a_i & {WIDTH{b_i[j]}})) == (a_i & {WIDTH{b_i[j]}}));
  end

  p_zero_a_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_i == '0 |-> en_o == '0);

  p_zero_b_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_i == '0 |-> en_o == '0);

  p_onehot_a_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(a_i) == 1 |-> $countones(en_o) == $countones(b_i[WIDTH-1:1]));

  p_onehot_b_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(b_i) == 1 |-> $countones(en_o) == (b_i[0] ? 0 : $countones(a_i)));
endmodule

bind rcb_mult rcb_mult_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .a_i    (a_i),
  .b_i    (b_i),
  .p_o    (p_o),
  .en_o   (en_o)
);

// File: tb/rcb_mult_tb_top.sv
`timescale 1ns/1ps
module rcb_mult_tb_top;
  localparam int W = 12;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic                 clk_i = 1'b0;
  logic                 rst_ni = 1'b0;
  logic [W-1:0]         a_i = W'(5);
  logic [W-1:0]         b_i = W'(7);
  logic [2*W-1:0]       p_o;
  logic [(W-1)*W-1:0]   en_o;

  logic [2*W-1:0] exp_q[$];
  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  rcb_mult #(.WIDTH(W)) dut_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_i    (a_i),
    .b_i    (b_i),
    .p_o    (p_o),
    .en_o   (en_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b);
    int cnt;
    int miss;
    @(negedge clk_i);
    a_i = a;
    b_i = b;
    #1;
    cnt = $countones(en_o);
    miss = 0;
    // R3: every cell with a[i]&b[j]=1 is active
    for (int j = 1; j < W; j++) begin
      for (int i = 0; i < W; i++) begin
        if (a[i] && b[j] && !en_o[(j-1)*W + i]) miss++;
      end
    end
    check(miss == 0, "R3 active where partial product set", miss, 0);
    if (a == '0) check(cnt == 0, "R4 zero multiplicand enables", cnt, 0);
    if (b == '0) check(cnt == 0, "R5 zero multiplier enables", cnt, 0);
    if ($countones(a) == 1)
      check(cnt == $countones(b[W-1:1]), "R6 single-bit multiplicand enables",
            cnt, $countones(b[W-1:1]));
    if ($countones(b) == 1)
      check(cnt == (b[0] ? 0 : $countones(a)), "R7 single-bit multiplier enables",
            cnt, (b[0] ? 0 : $countones(a)));
    exp_q.push_back({{W{1'b0}}, a} * {{W{1'b0}}, b});
  endtask

  // monitor: product is due one rising edge after drive
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (rst_ni && exp_q.size() > 0) begin
        logic [2*W-1:0] e;
        e = exp_q.pop_front();
        check(p_o == e, "R1/R8 product", p_o, e);
      end
    end
  end

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #22;
    check(p_o == '0, "R2 product cleared in reset", p_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    drive('0, '0);
    drive('0, ONES);
    drive(ONES, '0);
    drive(ONES, ONES);
    drive(W'(1), ONES);
    drive(ONES, W'(1));
    for (int k = 0; k < W; k++) begin
      drive(W'(1) << k, ONES);
      drive(ONES, W'(1) << k);
      drive(W'(1) << k, W'(1) << (W - 1 - k));
      drive(W'($urandom), W'(1) << k);
      drive(W'(1) << k, W'($urandom));
    end
    for (int n = 0; n < 1500; n++) drive(W'($urandom), W'($urandom));

    while (exp_q.size() > 0) @(negedge clk_i);
    repeat (2) @(negedge clk_i);

    a_i = ONES;
    b_i = ONES;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(p_o == '0, "R2 product cleared on mid-run reset", p_o, 0);
    repeat (2) @(negedge clk_i);
    check(p_o == '0, "R2 product held while reset low", p_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule